// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a simple register bus. The bus writes 16-bit words and reads bytes. Every write must carry a key in its upper byte, and each register has its own key. A write whose key does not match that register's key is dropped. Three registers are mapped:

- a control word: timer mode, run enable and count rate;
- a live 8-bit up-counter;
- a reset-control word: the reset enable and a sticky overflow flag.

A prescaler divides the clock by one of eight power-of-four ratios and feeds the counter. When the counter wraps from 255 to 0 in watchdog mode, the flag is latched. If reset is enabled, a fixed-length reset pulse is also driven. Software services the watchdog by writing the counter back to a low value before it wraps.

Clearing the flag is guarded. A clear request uses the reset-control offset with a key that differs from the normal write key. It takes effect only after software has read the flag while it was set. A flag set by a later overflow needs a new read before it can be cleared.

Top module: `keyed_watchdog`

## Requirements
- R1: At offset 0, a write with upper byte 0xA5 stores the lower byte as the control word. In that word, bit 6 selects watchdog mode, bit 5 enables counting and bits 2:0 select the rate. A read of offset 0 returns the stored byte.
- R2: At offset 2, a write with upper byte 0x5A loads the lower byte into the counter. A read of offset 2 returns the current count.
- R3: At offset 4, a write with upper byte 0x5A copies lower-byte bit 6 into the reset enable. A read of offset 4 returns the flag in bit 7, the reset enable in bit 6 and zeros below.
- R4: Any of the following changes no register: a write to offset 0 whose key is not 0xA5, a write to offset 2 whose key is not 0x5A, a write to offset 4 whose key is neither 0x5A nor 0xA5, or a write to an unmapped offset (1, 3, 5, 6 or 7).
- R5: With counting enabled and rate code k, the counter advances once every 2^(2+2k) clocks. The first advance comes on the 2^(2+2k)-th rising edge after the edge that enabled counting.
- R6: Writing the control word with bit 5 clear stops counting, and the counter holds its value.
- R7: A wrap of the counter from 255 to 0 sets the flag only in watchdog mode. In interval mode the same wrap leaves the flag clear.
- R8: A watchdog-mode wrap with reset enabled drives the reset output high for exactly 32 clocks. With reset disabled, the output stays low.
- R9: At offset 4, a write with upper byte 0xA5 clears the flag only if a read of offset 4 has returned the flag as 1 since the flag was last set. Otherwise the flag stays set.
- R10: After reset, all three registers read 0 and the reset output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 3 | Write byte offset |
| wrData | input | 16 | Write data: key in bits 15:8, value in bits 7:0 |
| rdEn | input | 1 | Read strobe; qualifies the flag read used by R9 |
| rdAddr | input | 3 | Read byte offset |
| rdData | output | 8 | Read data, combinational from rdAddr |
| wdtReset | output | 1 | Reset pulse request on watchdog overflow |

## Verification
The assertions assume that the bus strobes are single-cycle and synchronous to the clock. They also assume that a read strobe is what qualifies a flag observation, so that sampling rdData alone never arms a clear. The bench respects this. It drives every strobe for exactly one cycle, changes inputs only on the falling edge, and arms a clear only through an explicit read task. It never leaves a read strobe asserted while it expects a clear to be refused.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W  = 8;
  localparam int RATE_W = 3;
  localparam int ADDR_W = 3;

  localparam logic [7:0] KEY_CTRL  = 8'hA5;
  localparam logic [7:0] KEY_COUNT = 8'h5A;
  localparam logic [7:0] KEY_RSTEN = 8'h5A;
  localparam logic [7:0] KEY_CLEAR = 8'hA5;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RSTC  = 3'd4;

  // strobes and configuration passed from control to datapath
  typedef struct packed {
    logic              cntLoad;
    logic [CNT_W-1:0]  cntVal;
    logic              runEn;
    logic              wdMode;
    logic              rstEn;
    logic [RATE_W-1:0] rateSel;
  } wdtCmd_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfTick,
  output wdtCmd_t           cmd,
  output logic [7:0]        rdData
);
  logic [7:0] ctrlReg;
  logic       rstEnReg;
  logic       ovfFlag;
  logic       armed;

  logic [7:0] wKey;
  logic [7:0] wVal;
  logic       ctrlWr, countWr, rstEnWr, clearReq, flagSet, flagRead, flagClr;

  assign wKey = wrData[15:8];
  assign wVal = wrData[7:0];

  always_comb begin
    ctrlWr   = wrEn && (wrAddr == OFS_CTRL)  && (wKey == KEY_CTRL);
    countWr  = wrEn && (wrAddr == OFS_COUNT) && (wKey == KEY_COUNT);
    rstEnWr  = wrEn && (wrAddr == OFS_RSTC)  && (wKey == KEY_RSTEN);
    clearReq = wrEn && (wrAddr == OFS_RSTC)  && (wKey == KEY_CLEAR);
    flagSet  = ovfTick && ctrlReg[6];
    flagRead = rdEn && (rdAddr == OFS_RSTC) && ovfFlag;
    flagClr  = clearReq && armed && !flagSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      rstEnReg <= 1'b0;
    end else begin
      if (ctrlWr)  ctrlReg  <= wVal;
      if (rstEnWr) rstEnReg <= wVal[6];
    end
  end

  // overflow flag with read-before-clear qualifier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
      armed   <= 1'b0;
    end else if (flagSet) begin
      ovfFlag <= 1'b1;
      armed   <= 1'b0;
    end else if (flagClr) begin
      ovfFlag <= 1'b0;
      armed   <= 1'b0;
    end else if (flagRead) begin
      armed   <= 1'b1;
    end
  end

  always_comb begin
    cmd.cntLoad = countWr;
    cmd.cntVal  = wVal[CNT_W-1:0];
    cmd.runEn   = ctrlReg[5];
    cmd.wdMode  = ctrlReg[6];
    cmd.rstEn   = rstEnReg;
    cmd.rateSel = ctrlReg[RATE_W-1:0];
  end

  always_comb begin
    unique case (rdAddr)
      OFS_CTRL:  rdData = ctrlReg;
      OFS_COUNT: rdData = 8'(count);
      OFS_RSTC:  rdData = {ovfFlag, rstEnReg, 6'b0};
      default:   rdData = 8'h00;
    endcase
  end

  p_ctrl_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == OFS_CTRL && wKey != KEY_CTRL) |=> $stable(ctrlReg));

  p_rsten_key_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !(wrAddr == OFS_RSTC && wKey == KEY_RSTEN)) |=> $stable(rstEnReg));

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTick && cmd.wdMode) |=> ovfFlag);

  p_clear_needs_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(armed));
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtCmd_t          cmd,
  output logic [CNT_W-1:0] count,
  output logic             ovfTick,
  output logic             wdtReset
);
  localparam int MAX_RATE = (1 << RATE_W) - 1;
  localparam int PRE_W    = 2 + 2 * MAX_RATE;
  localparam int SH_W     = $clog2(PRE_W + 1);
  localparam int PL_W     = $clog2(PULSE_LEN + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLimit;
  logic [SH_W-1:0]  shAmt;
  logic             tick;
  logic [PL_W-1:0]  pulseCnt;

  // terminal count = 2^(2+2k) - 1
  always_comb begin
    shAmt    = SH_W'(PRE_W - 2) - SH_W'({cmd.rateSel, 1'b0});
    preLimit = {PRE_W{1'b1}} >> shAmt;
    tick     = cmd.runEn && (preCnt >= preLimit);
    ovfTick  = tick && (count == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (!cmd.runEn)     preCnt <= '0;
    else if (tick)           preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (cmd.cntLoad) count <= cmd.cntVal;
    else if (tick)        count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pulseCnt <= '0;
    else if (ovfTick && cmd.wdMode && cmd.rstEn)
      pulseCnt <= PL_W'(PULSE_LEN);
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - 1'b1;
  end

  assign wdtReset = (pulseCnt != '0);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.runEn && !cmd.cntLoad) |=> $stable(count));

  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntLoad |=> (count == $past(cmd.cntVal)));

  p_reset_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdtReset) |-> $past(ovfTick && cmd.wdMode && cmd.rstEn));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [15:0]       wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              wdtReset
);
  wdtCmd_t          cmd;
  logic [CNT_W-1:0] count;
  logic             ovfTick;

  wdt_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdEn    (rdEn),
    .rdAddr  (rdAddr),
    .count   (count),
    .ovfTick (ovfTick),
    .cmd     (cmd),
    .rdData  (rdData)
  );

  wdt_datapath #(.PULSE_LEN(PULSE_LEN)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .count    (count),
    .ovfTick  (ovfTick),
    .wdtReset (wdtReset)
  );
endmodule

// File: tb/test_keyed_watchdog.sv
module test_keyed_watchdog;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [2:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic        wdtReset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_watchdog i_keyed_watchdog (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .wdtReset(wdtReset)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // peek: look at read data without the read strobe
  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rdAddr = a;
    #1 v = rdData;
  endtask

  // strobed read: qualifies a flag observation
  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    #1 v = rdData;
    @(posedge clk);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    peek(3'd0, v); check("R10 ctrl", v, 8'h00);
    peek(3'd2, v); check("R10 count", v, 8'h00);
    peek(3'd4, v); check("R10 rstctl", v, 8'h00);
    check("R10 reset out", wdtReset, 0);
  endtask

  task automatic testBadKeys();
    logic [7:0] v;
    wr(3'd0, 16'h5A65); peek(3'd0, v); check("R4 ctrl bad key", v, 8'h00);
    wr(3'd2, 16'hA533); peek(3'd2, v); check("R4 count bad key", v, 8'h00);
    wr(3'd4, 16'h1240); peek(3'd4, v); check("R4 rstctl bad key", v, 8'h00);
    wr(3'd6, 16'hA565); wr(3'd1, 16'h5A77);
    peek(3'd0, v); check("R4 unmapped ctrl", v, 8'h00);
    peek(3'd2, v); check("R4 unmapped count", v, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] v;
    wr(3'd0, 16'hA547); peek(3'd0, v); check("R1 ctrl readback", v, 8'h47);
    wr(3'd0, 16'hA500); peek(3'd0, v); check("R1 ctrl cleared", v, 8'h00);
    wr(3'd2, 16'h5A3C); peek(3'd2, v); check("R2 count load", v, 8'h3C);
  endtask

  task automatic testRate(input int code);
    logic [7:0] v;
    int period = 1 << (2 + 2 * code);
    wr(3'd2, 16'h5A00);
    wr(3'd0, 16'hA520 | 16'(code));
    repeat (period - 1) @(posedge clk);
    peek(3'd2, v); check($sformatf("R5 rate %0d before first tick", code), v, 0);
    repeat (1) @(posedge clk);
    peek(3'd2, v); check($sformatf("R5 rate %0d first tick", code), v, 1);
    repeat (period) @(posedge clk);
    peek(3'd2, v); check($sformatf("R5 rate %0d second tick", code), v, 2);
    wr(3'd0, 16'hA500);
  endtask

  task automatic testHold();
    logic [7:0] v;
    logic [7:0] held;
    wr(3'd2, 16'h5A10);
    wr(3'd0, 16'hA520);
    repeat (20) @(posedge clk);
    wr(3'd0, 16'hA500);
    peek(3'd2, held);
    repeat (100) @(posedge clk);
    peek(3'd2, v); check("R6 held after disable", v, held);
    check("R6 count had advanced", int'(held > 8'h10), 1);
  endtask

  task automatic testIntervalWrap();
    logic [7:0] v;
    int hi = 0;
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA520);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); if (wdtReset) hi++;
    end
    wr(3'd0, 16'hA500);
    peek(3'd4, v); check("R7 no flag in interval mode", v, 8'h00);
    check("R8 no pulse in interval mode", hi, 0);
  endtask

  task automatic testWatchdogPulse();
    logic [7:0] v;
    int hi = 0;
    wr(3'd4, 16'h5A40);
    peek(3'd4, v); check("R3 reset enable readback", v, 8'h40);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (wdtReset) hi++;
    end
    wr(3'd0, 16'hA500);
    check("R8 pulse length", hi, 32);
    peek(3'd4, v); check("R7 flag set", v, 8'hC0);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R9 clear refused without read", v, 8'hC0);
    rd(3'd4, v); check("R9 read shows flag", v, 8'hC0);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R9 clear after read", v, 8'h40);
  endtask

  task automatic overflowNow();
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    repeat (6) @(posedge clk);
    wr(3'd0, 16'hA500);
  endtask

  task automatic testNoResetAndRearm();
    logic [7:0] v;
    int hi = 0;
    wr(3'd4, 16'h5A00);
    wr(3'd2, 16'h5AFF);
    wr(3'd0, 16'hA560);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (wdtReset) hi++;
    end
    wr(3'd0, 16'hA500);
    check("R8 no pulse with reset disabled", hi, 0);
    peek(3'd4, v); check("R7 flag set without reset", v, 8'h80);
    rd(3'd4, v);
    overflowNow();
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R9 new overflow disarms clear", v, 8'h80);
    rd(3'd4, v);
    wr(3'd4, 16'hA500);
    peek(3'd4, v); check("R9 clear after fresh read", v, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testBadKeys();
    testRegs();
    testRate(0);
    testRate(1);
    testRate(2);
    testHold();
    testIntervalWrap();
    testWatchdogPulse();
    testNoResetAndRearm();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule